// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Guard

This block sits between the host write path and a page write controller of a byte-wide nonvolatile memory. Every write the host issues arrives as an event carrying a 13-bit address and an 8-bit data byte. The block compares the event stream against two fixed key sequences. A three-write key turns protection on. A six-write key turns it off. Writes that are not part of a key are either passed on for storage or dropped, depending on the current protect state. In both cases a programming period still starts, and for that period the block reports busy.

A load period opens with the first write and closes once `LOAD_WIN` cycles pass with no further write. The block then pulses `prog_start` and holds `busy` for `PROG_CYC` cycles. A key applied in a load period takes effect at the end of the programming period that follows it. The protect bit ignores the ordinary reset. It changes only at that point, or when a separate power-on strobe loads a chosen value, so a bench can model retention of the bit across power cycles.

Top module: `sdp_guard`

## Requirements
- R1: The arm key is three writes in one load period, as (address, data) in hex: (1555, AA), (0AAA, 55), (1555, A0). Key writes are never presented on the commit outputs. At the end of the programming period that follows, `prot_on` becomes 1.
- R2: The disarm key is six writes in one load period: (1555, AA), (0AAA, 55), (1555, 80), (1555, AA), (0AAA, 55), (1555, 20). At the end of the programming period that follows, `prot_on` becomes 0.
- R3: `prot_on` keeps its old value during the load period and during the programming period. It changes only at the edge where `busy` falls, and it changes even when no user byte followed the key.
- R4: With `prot_on`=1, every write that follows a complete key in the same load period is committed.
- R5: With `prot_on`=1, a write that follows no key is not committed. It still opens a load period, and a programming period with `busy`=1 follows.
- R6: With `prot_on`=0, ordinary writes are committed. This includes writes to a key address with non-key data.
- R7: A write that breaks a partly matched key sends the matcher back to its first step. That write is handled as ordinary data under the current protect state, and the key writes matched before it are not committed.
- R8: A load period closes after `LOAD_WIN` consecutive cycles with no write. `prog_start` pulses and `busy` rises on the `LOAD_WIN`-th clock edge after the last write. A key cut by such a gap is abandoned.
- R9: `busy` stays high for exactly `PROG_CYC` cycles. Writes presented while `busy`=1 are ignored: they are not committed and do not lengthen the period.
- R10: `rst` does not change `prot_on`. A clock edge with `por`=1 loads `prot_on` from `por_prot`.
- R11: A committed write appears on `commit_vld`, `commit_addr` and `commit_data` one cycle after the write, with the same address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (protect bit excluded) |
| por | input | 1 | Power-on strobe loading the protect bit |
| por_prot | input | 1 | Value loaded into the protect bit on `por` |
| wr_vld | input | 1 | Host write event valid |
| wr_addr | input | 13 | Host write address |
| wr_data | input | 8 | Host write data |
| commit_vld | output | 1 | User byte to store |
| commit_addr | output | 13 | Address of the byte to store |
| commit_data | output | 8 | Byte to store |
| prog_start | output | 1 | One-cycle pulse starting a programming period |
| busy | output | 1 | Programming period in progress |
| prot_on | output | 1 | Current protect state |

## Verification
The bench builds the block with `LOAD_WIN`=8 and `PROG_CYC`=20. With a window of eight cycles, a key sent back to back fits inside it, and a pause of eight idle cycles cuts a key in half, so both the abandoned-key case and the close-of-period edge can be reached in a few dozen cycles. The twenty-cycle programming period leaves room to inject a write while `busy` is high and still count the exact busy length, and to watch `prot_on` hold its value until `busy` falls.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [2:0]        step_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } wr_evt_t;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_ARM    = 2'd1,
        KIND_DISARM = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_LOAD = 2'd1,
        T_PROG = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        EV_CMD        = 2'd0,
        EV_DATA_OPEN  = 2'd1,
        EV_DATA_PLAIN = 2'd2
    } ev_class_e;

    localparam addr_t KEY_ADDR_HI = 13'h1555;
    localparam addr_t KEY_ADDR_LO = 13'h0AAA;
    localparam data_t KEY_BYTE_0  = 8'hAA;
    localparam data_t KEY_BYTE_1  = 8'h55;
    localparam data_t OP_ARM      = 8'hA0;
    localparam data_t OP_UNLOCK   = 8'h80;
    localparam data_t OP_CLEAR    = 8'h20;

    localparam step_t STEP_FORK = 3'd2;
    localparam step_t STEP_LAST = 3'd5;

    // Expected pair on the disarm path for a given step; step 2 also
    // accepts the arm opcode, checked separately.
    function automatic wr_evt_t step_pair(step_t s);
        wr_evt_t p;
        case (s)
            3'd0, 3'd3: p = '{addr: KEY_ADDR_HI, data: KEY_BYTE_0};
            3'd1, 3'd4: p = '{addr: KEY_ADDR_LO, data: KEY_BYTE_1};
            3'd2:       p = '{addr: KEY_ADDR_HI, data: OP_UNLOCK};
            3'd5:       p = '{addr: KEY_ADDR_HI, data: OP_CLEAR};
            default:    p = '{addr: KEY_ADDR_HI, data: KEY_BYTE_0};
        endcase
        return p;
    endfunction

    function automatic logic is_arm_op(wr_evt_t e);
        return (e.addr == KEY_ADDR_HI) && (e.data == OP_ARM);
    endfunction

endpackage

// File: rtl/sdp_seq_match.sv
module sdp_seq_match
    import sdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ev_vld,
    input  wr_evt_t   ev,
    input  logic      clear,
    output ev_class_e cls,
    output cmd_kind_e kind_q
);

    step_t step_q;
    logic  pair_hit;
    logic  arm_hit;

    always_comb begin
        pair_hit = (ev == step_pair(step_q));
        arm_hit  = (step_q == STEP_FORK) && is_arm_op(ev);
        if (kind_q != KIND_NONE)
            cls = EV_DATA_OPEN;
        else if (pair_hit || arm_hit)
            cls = EV_CMD;
        else
            cls = EV_DATA_PLAIN;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            step_q <= '0;
            kind_q <= KIND_NONE;
        end else if (ev_vld && (kind_q == KIND_NONE)) begin
            if (arm_hit) begin
                kind_q <= KIND_ARM;
                step_q <= '0;
            end else if (pair_hit) begin
                if (step_q == STEP_LAST) begin
                    kind_q <= KIND_DISARM;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 3'd1;
                end
            end else begin
                step_q <= '0;
            end
        end
    end

    // R7: the step index never leaves the key length
    a_r7_step_range: assert property (@(posedge clk) disable iff (rst)
        step_q <= STEP_LAST);

    // R1: arming can only complete from the fork step
    a_r1_arm_from_fork: assert property (@(posedge clk) disable iff (rst)
        (ev_vld && kind_q == KIND_NONE && step_q != STEP_FORK && !clear)
            |=> kind_q != KIND_ARM);

endmodule

// File: rtl/sdp_load_timer.sv
module sdp_load_timer
    import sdp_pkg::*;
#(
    parameter int LOAD_WIN = 7500,
    parameter int PROG_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_vld,
    output logic accept,
    output logic busy,
    output logic prog_start,
    output logic prog_done
);

    localparam int GAP_W = $clog2(LOAD_WIN + 1);
    localparam int PRG_W = $clog2(PROG_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_END = GAP_W'(LOAD_WIN - 1);
    localparam logic [PRG_W-1:0] PRG_END = PRG_W'(PROG_CYC - 1);

    tmr_state_e       state_q;
    logic [GAP_W-1:0] gap_q;
    logic [PRG_W-1:0] prg_q;

    assign busy      = (state_q == T_PROG);
    assign accept    = wr_vld && !busy;
    assign prog_done = busy && (prg_q == PRG_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= T_IDLE;
            gap_q      <= '0;
            prg_q      <= '0;
            prog_start <= 1'b0;
        end else begin
            prog_start <= 1'b0;
            case (state_q)
                T_IDLE: begin
                    if (accept) begin
                        state_q <= T_LOAD;
                        gap_q   <= '0;
                    end
                end
                T_LOAD: begin
                    if (accept) begin
                        gap_q <= '0;
                    end else if (gap_q == GAP_END) begin
                        state_q    <= T_PROG;
                        prg_q      <= '0;
                        prog_start <= 1'b1;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                T_PROG: begin
                    if (prog_done)
                        state_q <= T_IDLE;
                    else
                        prg_q <= prg_q + 1'b1;
                end
                default: state_q <= T_IDLE;
            endcase
        end
    end

    // R8: the start pulse coincides with the programming period
    a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> busy);

    // R8: a programming period is only entered through the start pulse
    a_r8_rise_with_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> prog_start);

    // R9: the period counter stays within the programming length
    a_r9_prog_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> prg_q <= PRG_END);

endmodule

// File: rtl/sdp_prot_hold.sv
module sdp_prot_hold
    import sdp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      por,
    input  logic      por_val,
    input  logic      done,
    input  cmd_kind_e kind,
    output logic      prot_q
);

    // Deliberately outside the ordinary reset domain.
    always_ff @(posedge clk) begin
        if (por)
            prot_q <= por_val;
        else if (done && kind == KIND_ARM)
            prot_q <= 1'b1;
        else if (done && kind == KIND_DISARM)
            prot_q <= 1'b0;
    end

    // R3: no change outside the end of a programming period
    a_r3_prot_hold: assert property (@(posedge clk) disable iff (rst)
        (!por && !done) |=> $stable(prot_q));

    // R10: the power-on strobe loads the supplied value
    a_r10_por_load: assert property (@(posedge clk) disable iff (rst)
        por |=> prot_q == $past(por_val));

endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
    import sdp_pkg::*;
#(
    parameter int LOAD_WIN = 7500,
    parameter int PROG_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              por_prot,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit_vld,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              prog_start,
    output logic              busy,
    output logic              prot_on
);

    wr_evt_t   ev;
    ev_class_e cls;
    cmd_kind_e kind;
    logic      accept;
    logic      prog_done;
    logic      store;

    assign ev = '{addr: wr_addr, data: wr_data};

    sdp_load_timer #(
        .LOAD_WIN (LOAD_WIN),
        .PROG_CYC (PROG_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .wr_vld     (wr_vld),
        .accept     (accept),
        .busy       (busy),
        .prog_start (prog_start),
        .prog_done  (prog_done)
    );

    sdp_seq_match u_match (
        .clk    (clk),
        .rst    (rst),
        .ev_vld (accept),
        .ev     (ev),
        .clear  (prog_done),
        .cls    (cls),
        .kind_q (kind)
    );

    sdp_prot_hold u_prot (
        .clk     (clk),
        .rst     (rst),
        .por     (por),
        .por_val (por_prot),
        .done    (prog_done),
        .kind    (kind),
        .prot_q  (prot_on)
    );

    always_comb begin
        store = 1'b0;
        if (accept) begin
            if (cls == EV_DATA_OPEN)
                store = 1'b1;
            else if (cls == EV_DATA_PLAIN)
                store = !prot_on;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_vld  <= 1'b0;
            commit_addr <= '0;
            commit_data <= '0;
        end else begin
            commit_vld <= store;
            if (store) begin
                commit_addr <= ev.addr;
                commit_data <= ev.data;
            end
        end
    end

    // R11: a commit always follows a host write one cycle earlier
    a_r11_commit_follows: assert property (@(posedge clk) disable iff (rst)
        commit_vld |-> $past(wr_vld));

    // R9: nothing offered during a programming period is committed
    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && busy) |=> !commit_vld);

    // R5: a plain write under protection stores nothing
    a_r5_locked_drop: assert property (@(posedge clk) disable iff (rst)
        (accept && prot_on && cls == EV_DATA_PLAIN) |=> !commit_vld);

endmodule

// File: tb/tb_sdp_guard.sv
module tb_sdp_guard;
    import sdp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LOAD_WIN   = 8;
    localparam int PROG_CYC   = 20;

    logic        clk = 1'b0;
    logic        rst, por, por_prot;
    logic        wr_vld;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        commit_vld, prog_start, busy, prot_on;
    logic [12:0] commit_addr;
    logic [7:0]  commit_data;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R11";
    logic [20:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdp_guard #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) dut (
        .clk(clk), .rst(rst), .por(por), .por_prot(por_prot),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_vld(commit_vld), .commit_addr(commit_addr),
        .commit_data(commit_data), .prog_start(prog_start),
        .busy(busy), .prot_on(prot_on));

    task automatic chk(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every commit is matched against the queue (R11)
    always @(negedge clk) begin
        if (!rst && commit_vld) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL %s unexpected commit: actual=%h_%h expected=none",
                         cur_req, commit_addr, commit_data);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                if ({commit_addr, commit_data} != e) begin
                    n_errors++;
                    $display("FAIL %s commit: actual=%h_%h expected=%h_%h",
                             cur_req, commit_addr, commit_data, e[20:8], e[7:0]);
                end
            end
        end
    end

    task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit keep);
        if (keep) exp_q.push_back({a, d});
        wr_addr = a;
        wr_data = d;
        wr_vld  = 1'b1;
        @(negedge clk);
        wr_vld  = 1'b0;
    endtask

    task automatic arm_key();
        wr(13'h1555, 8'hAA, 0);
        wr(13'h0AAA, 8'h55, 0);
        wr(13'h1555, 8'hA0, 0);
    endtask

    task automatic disarm_key();
        wr(13'h1555, 8'hAA, 0);
        wr(13'h0AAA, 8'h55, 0);
        wr(13'h1555, 8'h80, 0);
        wr(13'h1555, 8'hAA, 0);
        wr(13'h0AAA, 8'h55, 0);
        wr(13'h1555, 8'h20, 0);
    endtask

    // Called right after the last write; checks window, busy length and
    // the moment the protect bit moves.
    task automatic close_period(input bit pb, input bit pa, input bit poke);
        int n;
        n = 0;
        while (!busy && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R8", n, LOAD_WIN, "cycles from last write to busy");
        chk("R8", prog_start, 1, "prog_start with busy");
        chk("R3", prot_on, pb, "protect held during busy");
        n = 0;
        while (busy && n < 100) begin
            if (poke && n == 3) begin
                wr_addr = 13'h0777;
                wr_data = 8'hEE;
                wr_vld  = 1'b1;
            end else begin
                wr_vld  = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        wr_vld = 1'b0;
        chk("R9", n, PROG_CYC, "busy length");
        chk("R3", prot_on, pa, "protect after period");
        chk(cur_req, exp_q.size(), 0, "pending expected commits");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; por = 1'b1; por_prot = 1'b0;
        wr_vld = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;
        @(negedge clk);
        chk("R10", prot_on, 0, "protect after power-on");
        chk("R9", busy, 0, "busy after reset");
        chk("R11", commit_vld, 0, "commit after reset");

        cur_req = "R6";
        wr(13'h0010, 8'h11, 1);
        wr(13'h0011, 8'h22, 1);
        wr(13'h1555, 8'h5A, 1);
        close_period(0, 0, 0);

        cur_req = "R1";
        arm_key();
        wr(13'h0040, 8'h33, 1);
        close_period(0, 1, 0);

        cur_req = "R5";
        wr(13'h0050, 8'h44, 0);
        close_period(1, 1, 1);

        cur_req = "R10";
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10", prot_on, 1, "protect kept over reset");
        rst = 1'b1; por = 1'b1; por_prot = 1'b0;
        @(negedge clk);
        rst = 1'b0; por = 1'b0;
        chk("R10", prot_on, 0, "protect loaded from por value");

        cur_req = "R3";
        arm_key();
        close_period(0, 1, 0);

        cur_req = "R4";
        arm_key();
        wr(13'h0100, 8'h66, 1);
        wr(13'h0101, 8'h77, 1);
        close_period(1, 1, 0);

        cur_req = "R7";
        wr(13'h1555, 8'hAA, 0);
        wr(13'h0AAA, 8'h55, 0);
        wr(13'h0AAA, 8'h12, 0);
        wr(13'h0200, 8'h13, 0);
        close_period(1, 1, 0);

        cur_req = "R8";
        wr(13'h1555, 8'hAA, 0);
        wr(13'h0AAA, 8'h55, 0);
        close_period(1, 1, 0);
        wr(13'h1555, 8'hA0, 0);
        close_period(1, 1, 0);

        cur_req = "R2";
        disarm_key();
        wr(13'h0300, 8'h88, 1);
        close_period(1, 0, 0);

        cur_req = "R6";
        wr(13'h0301, 8'h99, 1);
        close_period(0, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule